// File: doc/BRIEF.md
# Beamformer Channel Lane: Aligning Delay, Leading Window and Parallel FIR

This block is one lane of a time-domain space-time beamformer. It takes one signed 16-bit sample per clock from a single antenna channel. At the start of each voxel it captures two values: an integer alignment delay and a start index. It also holds a vector of FIR weights, which is shifted in serially before filtering and stays fixed for the whole voxel.

Each accepted sample moves through three stages. The first is a delay line that shifts the channel by the programmed number of samples. The second is a leading window that forces to zero every aligned sample whose position since the voxel start is below the start index. The third is a fully parallel FIR with one multiplier per weight and a registered adder tree. All arithmetic after the input is carried at 64 bits. Several lanes run side by side, and their aligned outputs are summed outside this block.

A voxel starts with a one-cycle clear pulse. The pulse captures the new delay and start index and empties the delay history, the position counter and the FIR taps. It does not touch the weights.

Top module: `bfl_channel_lane`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, out_valid is 0 and out_data is 0.
- R2: The i-th sample accepted after a clear reaches the window as x[i-d]. Here d is the delay captured at the clear and x[j] is 0 for j<0. A delay of 0 passes samples through unshifted.
- R3: A captured delay greater than D_MAX behaves exactly as a delay of D_MAX.
- R4: Aligned sample i, counted from 0 at the clear, is replaced by 0 when i is less than the start index captured at the clear. Otherwise it passes unchanged.
- R5: Output i equals the sum, over k from 0 to NTAPS-1, of w[k]·s[i-k]. Here s is the windowed sequence, s[j]=0 for j<0, and the result is a 64-bit signed value.
- R6: Each cycle with wt_load_en high shifts weights down by one place (w[k] takes w[k+1]) and writes wt_load_data into w[NTAPS-1]. After NTAPS loads, the first value loaded sits in w[0].
- R7: Every accepted input gives exactly one output, with out_valid high exactly 4+log2(NTAPS) cycles later. No output appears without an accepted input.
- R8: A clear cycle discards in_valid for that cycle, and it empties the delay history, the position counter and the FIR taps. Samples from before the clear never affect later outputs.
- R9: Full-scale negative samples and weights (-32768) are summed over all taps without overflow or wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Per-voxel start pulse: captures delay and start index, empties history |
| cfg_delay | input | DLY_IN_W | Alignment delay in samples, captured on clr |
| cfg_start | input | IDX_W | Start index of the leading window, captured on clr |
| wt_load_en | input | 1 | Shift one weight into the weight register |
| wt_load_data | input | 16 | Serial weight value, signed |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | 16 | Received sample, two's complement |
| out_valid | output | 1 | Filtered output valid |
| out_data | output | 64 | Filtered output, two's complement |

## Verification
An impulse stream with zero delay and an open window makes the lane print its own weight vector. That separates filter arithmetic and weight order from alignment. A ramp with a small delay, and another with a delay past the limit, separate correct shifting from clamping. A pseudo-random stream with both a delay and a start index shows whether the window counts positions after alignment, and not raw input positions. Full-scale negative values and a clear pulse that arrives together with a valid sample check the width of the arithmetic and the flushing of stale history.

// File: rtl/bfl_pkg.sv
package bfl_pkg;
    localparam int SAMP_W = 16;
    localparam int ACC_W  = 64;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic  vld;
        samp_t data;
    } sbeat_t;

    function automatic acc_t widen(input samp_t v);
        return acc_t'(v);
    endfunction
endpackage

// File: rtl/bfl_delay_line.sv
module bfl_delay_line
    import bfl_pkg::*;
#(
    parameter int D_MAX    = 15,
    parameter int DLY_IN_W = 8,
    localparam int DLY_W   = $clog2(D_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic [DLY_IN_W-1:0] cfg_delay,
    input  sbeat_t              din,
    output sbeat_t              dout
);
    samp_t             hist [D_MAX];
    logic [DLY_W-1:0]  dly_q;
    samp_t             pick;

    always_comb begin
        pick = din.data;
        for (int k = 1; k <= D_MAX; k++)
            if (int'(dly_q) == k) pick = hist[k-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
            dout  <= '0;
            for (int k = 0; k < D_MAX; k++) hist[k] <= '0;
        end else if (clr) begin
            dly_q <= (cfg_delay > DLY_IN_W'(D_MAX)) ? DLY_W'(D_MAX) : cfg_delay[DLY_W-1:0];
            dout  <= '0;
            for (int k = 0; k < D_MAX; k++) hist[k] <= '0;
        end else begin
            dout.vld <= din.vld;
            if (din.vld) begin
                dout.data <= pick;
                hist[0]   <= din.data;
                for (int k = 1; k < D_MAX; k++) hist[k] <= hist[k-1];
            end
        end
    end

    a_r3_delay_clamped: assert property (@(posedge clk) disable iff (rst)
        int'(dly_q) <= D_MAX);
endmodule

// File: rtl/bfl_window.sv
module bfl_window
    import bfl_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [IDX_W-1:0] cfg_start,
    input  sbeat_t           din,
    output sbeat_t           dout
);
    logic [IDX_W-1:0] pos_q;
    logic [IDX_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            start_q <= '0;
            dout    <= '0;
        end else if (clr) begin
            pos_q   <= '0;
            start_q <= cfg_start;
            dout    <= '0;
        end else begin
            dout.vld <= din.vld;
            if (din.vld) begin
                dout.data <= (pos_q < start_q) ? samp_t'(0) : din.data;
                if (pos_q != '1) pos_q <= pos_q + 1'b1;
            end
        end
    end

    a_r4_position_steps: assert property (@(posedge clk) disable iff (rst)
        (din.vld && !clr && pos_q != '1) |=> (pos_q == $past(pos_q) + 1'b1));
endmodule

// File: rtl/bfl_fir.sv
module bfl_fir
    import bfl_pkg::*;
#(
    parameter int NTAPS = 4,
    localparam int LVLS = $clog2(NTAPS),
    localparam int NP   = 1 << LVLS
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   wt_en,
    input  samp_t  wt_data,
    input  sbeat_t din,
    output logic   out_valid,
    output acc_t   out_data
);
    samp_t w    [NTAPS];
    samp_t taps [NTAPS];
    logic  tap_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NTAPS; k++) w[k] <= '0;
        end else if (wt_en) begin
            for (int k = 0; k < NTAPS - 1; k++) w[k] <= w[k+1];
            w[NTAPS-1] <= wt_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tap_vld <= 1'b0;
            for (int k = 0; k < NTAPS; k++) taps[k] <= '0;
        end else begin
            tap_vld <= din.vld;
            if (din.vld) begin
                taps[0] <= din.data;
                for (int k = 1; k < NTAPS; k++) taps[k] <= taps[k-1];
            end
        end
    end

    for (genvar lv = 0; lv <= LVLS; lv++) begin : g_lvl
        acc_t row [NP >> lv];
        logic vld;
        if (lv == 0) begin : g_mul
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld <= 1'b0;
                    for (int j = 0; j < NP; j++) row[j] <= '0;
                end else begin
                    vld <= tap_vld;
                    for (int j = 0; j < NP; j++)
                        row[j] <= (j < NTAPS) ? widen(taps[j]) * widen(w[j]) : acc_t'(0);
                end
            end
        end else begin : g_add
            always_ff @(posedge clk) begin
                if (rst) begin
                    vld <= 1'b0;
                    for (int j = 0; j < (NP >> lv); j++) row[j] <= '0;
                end else begin
                    vld <= g_lvl[lv-1].vld;
                    for (int j = 0; j < (NP >> lv); j++)
                        row[j] <= g_lvl[lv-1].row[2*j] + g_lvl[lv-1].row[2*j+1];
                end
            end
        end
    end

    assign out_valid = g_lvl[LVLS].vld;
    assign out_data  = g_lvl[LVLS].row[0];

    a_r6_weight_tail: assert property (@(posedge clk) disable iff (rst)
        wt_en |=> (w[NTAPS-1] == $past(wt_data)));
endmodule

// File: rtl/bfl_channel_lane.sv
module bfl_channel_lane
    import bfl_pkg::*;
#(
    parameter int NTAPS    = 4,
    parameter int D_MAX    = 15,
    parameter int IDX_W    = 16,
    parameter int DLY_IN_W = 8,
    localparam int LAT     = 4 + $clog2(NTAPS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic [DLY_IN_W-1:0]         cfg_delay,
    input  logic [IDX_W-1:0]            cfg_start,
    input  logic                        wt_load_en,
    input  logic signed [SAMP_W-1:0]    wt_load_data,
    input  logic                        in_valid,
    input  logic signed [SAMP_W-1:0]    in_sample,
    output logic                        out_valid,
    output logic signed [ACC_W-1:0]     out_data
);
    sbeat_t in_beat, dly_beat, win_beat;

    assign in_beat.vld  = in_valid && !clr;
    assign in_beat.data = in_sample;

    bfl_delay_line #(.D_MAX(D_MAX), .DLY_IN_W(DLY_IN_W)) u_dly (
        .clk(clk), .rst(rst), .clr(clr), .cfg_delay(cfg_delay),
        .din(in_beat), .dout(dly_beat)
    );

    bfl_window #(.IDX_W(IDX_W)) u_win (
        .clk(clk), .rst(rst), .clr(clr), .cfg_start(cfg_start),
        .din(dly_beat), .dout(win_beat)
    );

    bfl_fir #(.NTAPS(NTAPS)) u_fir (
        .clk(clk), .rst(rst), .clr(clr),
        .wt_en(wt_load_en), .wt_data(wt_load_data),
        .din(win_beat), .out_valid(out_valid), .out_data(out_data)
    );

    a_r8_clear_drops_input: assert property (@(posedge clk) disable iff (rst)
        clr |=> !dly_beat.vld);

    a_r7_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        in_beat.vld |-> ##LAT out_valid);
endmodule

// File: tb/bfl_channel_lane_tb_top.sv
module bfl_channel_lane_tb_top;
    localparam int NTAPS = 4;
    localparam int D_MAX = 15;
    localparam int LAT   = 4 + $clog2(NTAPS);

    logic clk = 1'b0, rst = 1'b1, clr = 1'b0;
    logic [7:0] cfg_delay = '0;
    logic [15:0] cfg_start = '0;
    logic wt_load_en = 1'b0, in_valid = 1'b0;
    logic signed [15:0] wt_load_data = '0, in_sample = '0;
    logic out_valid;
    logic signed [63:0] out_data;

    always #5 clk = ~clk;

    bfl_channel_lane #(.NTAPS(NTAPS), .D_MAX(D_MAX)) dut_i (
        .clk(clk), .rst(rst), .clr(clr), .cfg_delay(cfg_delay), .cfg_start(cfg_start),
        .wt_load_en(wt_load_en), .wt_load_data(wt_load_data),
        .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_data(out_data)
    );

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;
    longint exp_val[$];
    int     exp_cyc[$];
    string  exp_tag[$];

    longint wm [NTAPS];
    longint xs [$];
    longint sw [$];
    int     m_dly, m_start;
    string  cur_tag;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic load_weights(input longint a, input longint b, input longint c, input longint d);
        longint v [NTAPS];
        v[0] = a; v[1] = b; v[2] = c; v[3] = d;
        for (int k = 0; k < NTAPS; k++) begin
            @(negedge clk);
            wt_load_en = 1'b1; wt_load_data = 16'(v[k]);
            wm[k] = v[k];
        end
        @(negedge clk);
        wt_load_en = 1'b0;
    endtask

    task automatic start_voxel(input int d, input int st, input bit junk, input string tag);
        @(negedge clk);
        clr = 1'b1; cfg_delay = 8'(d); cfg_start = 16'(st);
        in_valid = junk; in_sample = 16'sd12345;
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0;
        m_dly = (d > D_MAX) ? D_MAX : d;
        m_start = st;
        xs.delete(); sw.delete();
        cur_tag = tag;
    endtask

    task automatic send(input longint v);
        longint dv, s, y;
        int i;
        i = xs.size();
        xs.push_back(v);
        dv = (i >= m_dly) ? xs[i - m_dly] : 0;
        s = (i < m_start) ? 0 : dv;
        sw.push_back(s);
        y = 0;
        for (int k = 0; k < NTAPS; k++)
            if (i - k >= 0) y += wm[k] * sw[i - k];
        in_valid = 1'b1; in_sample = 16'(v);
        exp_val.push_back(y);
        exp_cyc.push_back(cyc + LAT);
        exp_tag.push_back(cur_tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (LAT + 3) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            if (exp_val.size() == 0) begin
                check(1'b0, "R7 unexpected output", out_data, 0);
            end else begin
                longint ev; int ec; string et;
                ev = exp_val.pop_front(); ec = exp_cyc.pop_front(); et = exp_tag.pop_front();
                check(out_data == ev, et, out_data, ev);
                check(cyc == ec, "R7 latency", cyc, ec);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        longint lf;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_data == 0, "R1 reset outputs", out_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == 0, "R1 after release", out_data, 0);

        // R6 + R5: impulse reveals weight order
        load_weights(3, -5, 7, 11);
        start_voxel(0, 0, 0, "R5/R6 impulse");
        send(1); send(0); send(0); send(0); send(0);
        send(-2); send(0); send(0); send(0);
        drain();

        // R2: ramp with delay 3, back-to-back
        start_voxel(3, 0, 0, "R2 delay 3 ramp");
        for (int n = 1; n <= 12; n++) send(n * 100);
        drain();

        // R3: delay past the limit clamps
        start_voxel(40, 0, 0, "R3 clamp");
        for (int n = 1; n <= 22; n++) send(n - 7);
        drain();

        // R4: window after delay, pseudo-random data
        load_weights(-9, 2, 13, 1);
        start_voxel(2, 5, 0, "R4 window start 5");
        lf = 64'h1ACE;
        for (int n = 0; n < 16; n++) begin
            lf = (lf * 1103515245 + 12345) & 64'h7FFF_FFFF;
            send(longint'($signed(lf[23:8])));
        end
        drain();

        // R8: clear with junk valid, history from before must vanish
        start_voxel(1, 0, 1, "R8 after clear");
        for (int n = 0; n < 6; n++) send((n % 2) ? -300 : 250);
        drain();

        // R9: full-scale negative values
        load_weights(-32768, -32768, -32768, -32768);
        start_voxel(0, 0, 0, "R9 full scale");
        for (int n = 0; n < 6; n++) send(-32768);
        drain();

        check(exp_val.size() == 0, "R7 missing outputs", exp_val.size(), 0);
        finish_run();
    end
endmodule